// File: doc/BRIEF.md
# Boundary Scan Test Access Port with Output Override

This block is a four-wire test access port controller for a small device. It uses a serial clock, a mode select, a data input and a data output, and it has no separate test reset. A sixteen-state controller walks the mode select through the standard capture, shift, exit, pause and update paths. A 3-bit instruction register selects one data register. For the bypass instruction that register is a single flip-flop. For the sample/preload and external test instructions it is a boundary register that covers every input pin and both the data and the enable of every output pin.

While external test is in force, the output pins and their enables come from update latches in the boundary cells and not from the core. A global output-float request turns off every output enable under any other instruction, but it has no effect while external test is active. Chips are chained by wiring the serial output of one to the serial input of the next. A power-on reset input clears the controller for simulation and power-up only. It is not a test reset pin.

Top module: `tap_ctrl`

## Requirements
- R1: After power-on reset the controller is in Test-Logic-Reset, the bypass instruction is active, the serial output enable is low, and the pins follow the core.
- R2: Five rising clock edges with mode select held high reach Test-Logic-Reset from any state. Bypass is in force as soon as that state is entered.
- R3: The instruction register is 3 bits wide and shifts least significant bit first. Capture-IR loads 3'b101. Code 3'b000 is external test, 3'b001 is sample/preload and 3'b111 is bypass. Every other code acts as bypass.
- R4: Under bypass, the data path is one flip-flop. Capture-DR clears it, so the serial output gives 0 and then the serial input delayed by one clock.
- R5: The boundary register shifts from the serial input toward bit 0, and bit 0 drives the serial output. Bits [NIN-1:0] capture the input pins. For output j, bit NIN+2j captures the pin data and bit NIN+2j+1 captures the pin enable. Capture happens in Capture-DR under sample/preload or external test.
- R6: The output update latches change only on the clock edge that leaves Update-DR. While shifting, the driven pins stay stable.
- R7: Under external test, the pin data and the pin enables come from the update latches.
- R8: Under any instruction other than external test, the global float input forces every pin enable low. Under external test it has no effect.
- R9: The serial output and its enable change on the falling clock edge. The enable is high only in Shift-DR and Shift-IR.
- R10: Under bypass or sample/preload, the pins carry the core data and enables. A preload does not disturb them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| tdo_en | output | 1 | Drive enable for the serial output |
| gts | input | 1 | Global output-float request |
| pin_in | input | NIN | Values seen on the input pins |
| core_out | input | NOUT | Output data from core logic |
| core_oe | input | NOUT | Output enables from core logic |
| pin_out | output | NOUT | Data driven to the output pins |
| pin_oe | output | NOUT | Enables driven to the output pins |

## Verification
Each instruction is exercised by a full scan. The instruction scan reads back the capture pattern. A bypass scan with a mixed bit pattern shows that the data path is exactly one bit long and starts with 0. The same one-bit delay under an unassigned code shows that unused codes decode to bypass. A sample scan captures a known set of pin values and then preloads a different set, which shows that capture order and the preload path are separate. An external test scan checks that the pins hold steady through every shift and change only after update. The float request is toggled under both bypass and external test, and a forced reset is entered from the middle of a data shift.

// File: rtl/tap_ctrl.sv
`timescale 1ns/1ps
module tap_ctrl #(
  parameter int NIN  = 3,
  parameter int NOUT = 2
) (
  input  logic            tck,
  input  logic            por_n,
  input  logic            tms,
  input  logic            tdi,
  output logic            tdo,
  output logic            tdo_en,
  input  logic            gts,
  input  logic [NIN-1:0]  pin_in,
  input  logic [NOUT-1:0] core_out,
  input  logic [NOUT-1:0] core_oe,
  output logic [NOUT-1:0] pin_out,
  output logic [NOUT-1:0] pin_oe
);
  localparam int BLEN = NIN + 2*NOUT;
  localparam logic [2:0] OP_EXTEST = 3'b000;
  localparam logic [2:0] OP_SAMPLE = 3'b001;
  localparam logic [2:0] OP_BYPASS = 3'b111;
  localparam logic [2:0] IR_CAPT   = 3'b101;

  typedef enum logic [3:0] {
    EX2_DR = 4'h0, EX1_DR = 4'h1, SH_DR  = 4'h2, PAU_DR = 4'h3,
    SEL_IR = 4'h4, UPD_DR = 4'h5, CAP_DR = 4'h6, SEL_DR = 4'h7,
    EX2_IR = 4'h8, EX1_IR = 4'h9, SH_IR  = 4'hA, PAU_IR = 4'hB,
    RTI    = 4'hC, UPD_IR = 4'hD, CAP_IR = 4'hE, TLR    = 4'hF
  } st_t;

  st_t st, st_nx;
  logic [2:0]      ir, ir_sr;
  logic            byp;
  logic [BLEN-1:0] bsr, bcap;
  logic [NOUT-1:0] upd_out, upd_oe;

  always_comb begin
    case (st)
      TLR:     st_nx = tms ? TLR    : RTI;
      RTI:     st_nx = tms ? SEL_DR : RTI;
      SEL_DR:  st_nx = tms ? SEL_IR : CAP_DR;
      CAP_DR:  st_nx = tms ? EX1_DR : SH_DR;
      SH_DR:   st_nx = tms ? EX1_DR : SH_DR;
      EX1_DR:  st_nx = tms ? UPD_DR : PAU_DR;
      PAU_DR:  st_nx = tms ? EX2_DR : PAU_DR;
      EX2_DR:  st_nx = tms ? UPD_DR : SH_DR;
      UPD_DR:  st_nx = tms ? SEL_DR : RTI;
      SEL_IR:  st_nx = tms ? TLR    : CAP_IR;
      CAP_IR:  st_nx = tms ? EX1_IR : SH_IR;
      SH_IR:   st_nx = tms ? EX1_IR : SH_IR;
      EX1_IR:  st_nx = tms ? UPD_IR : PAU_IR;
      PAU_IR:  st_nx = tms ? EX2_IR : PAU_IR;
      EX2_IR:  st_nx = tms ? UPD_IR : SH_IR;
      UPD_IR:  st_nx = tms ? SEL_DR : RTI;
      default: st_nx = TLR;
    endcase
  end

  wire [2:0] instr     = (st == TLR) ? OP_BYPASS : ir;
  wire       extest    = (instr == OP_EXTEST);
  wire       bscan_sel = extest || (instr == OP_SAMPLE);

  always_comb begin
    bcap = '0;
    bcap[NIN-1:0] = pin_in;
    for (int j = 0; j < NOUT; j++) begin
      bcap[NIN+2*j]   = pin_out[j];
      bcap[NIN+2*j+1] = pin_oe[j];
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      st      <= TLR;
      ir      <= OP_BYPASS;
      ir_sr   <= '0;
      byp     <= 1'b0;
      bsr     <= '0;
      upd_out <= '0;
      upd_oe  <= '0;
    end else begin
      st <= st_nx;
      if (st == TLR)         ir <= OP_BYPASS;
      else if (st == UPD_IR) ir <= ir_sr;
      if (st == CAP_IR)      ir_sr <= IR_CAPT;
      else if (st == SH_IR)  ir_sr <= {tdi, ir_sr[2:1]};
      if (st == CAP_DR)      byp <= 1'b0;
      else if (st == SH_DR)  byp <= tdi;
      if (bscan_sel) begin
        if (st == CAP_DR)     bsr <= bcap;
        else if (st == SH_DR) bsr <= {tdi, bsr[BLEN-1:1]};
        else if (st == UPD_DR) begin
          for (int j = 0; j < NOUT; j++) begin
            upd_out[j] <= bsr[NIN+2*j];
            upd_oe[j]  <= bsr[NIN+2*j+1];
          end
        end
      end
    end
  end

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= (st == SH_IR) ? ir_sr[0] : (bscan_sel ? bsr[0] : byp);
      tdo_en <= (st == SH_IR) || (st == SH_DR);
    end
  end

  assign pin_out = extest ? upd_out : core_out;
  assign pin_oe  = extest ? upd_oe  : (gts ? '0 : core_oe);
endmodule

module tap_ctrl_chk #(
  parameter int NOUT = 2
) (
  input logic            tck,
  input logic            por_n,
  input logic            tms,
  input logic            gts,
  input logic [3:0]      st,
  input logic [2:0]      ir,
  input logic [2:0]      ir_sr,
  input logic            byp,
  input logic            tdo_en,
  input logic [NOUT-1:0] upd_out,
  input logic [NOUT-1:0] upd_oe,
  input logic [NOUT-1:0] pin_oe
);
  localparam logic [3:0] S_TLR = 4'hF, S_CAP_IR = 4'hE, S_CAP_DR = 4'h6,
                         S_UPD_DR = 4'h5, S_SH_DR = 4'h2, S_SH_IR = 4'hA;

  a_r2_tlr_hold: assert property (@(posedge tck) disable iff (!por_n)
    (st == S_TLR && tms) |=> (st == S_TLR));
  a_r1_tlr_bypass: assert property (@(posedge tck) disable iff (!por_n)
    (st == S_TLR) |=> (ir == 3'b111));
  a_r3_ir_capture: assert property (@(posedge tck) disable iff (!por_n)
    (st == S_CAP_IR) |=> (ir_sr == 3'b101));
  a_r4_bypass_clear: assert property (@(posedge tck) disable iff (!por_n)
    (st == S_CAP_DR) |=> (byp == 1'b0));
  a_r6_latch_hold: assert property (@(posedge tck) disable iff (!por_n)
    (st != S_UPD_DR) |=> ($stable(upd_out) && $stable(upd_oe)));
  a_r9_tdo_en_shift: assert property (@(posedge tck) disable iff (!por_n)
    tdo_en |-> (st == S_SH_DR || st == S_SH_IR));
  a_r8_float: assert property (@(posedge tck) disable iff (!por_n)
    (gts && ir != 3'b000) |-> (pin_oe == '0));
endmodule

bind tap_ctrl tap_ctrl_chk #(.NOUT(NOUT)) u_chk (
  .tck(tck), .por_n(por_n), .tms(tms), .gts(gts), .st(st), .ir(ir),
  .ir_sr(ir_sr), .byp(byp), .tdo_en(tdo_en), .upd_out(upd_out),
  .upd_oe(upd_oe), .pin_oe(pin_oe)
);

// File: tb/tb_tap_ctrl.sv
`timescale 1ns/1ps
module tb_tap_ctrl;
  localparam int NIN = 3, NOUT = 2, BLEN = NIN + 2*NOUT;
  logic tck = 1'b0, por_n = 1'b0, tms = 1'b1, tdi = 1'b0, gts = 1'b0;
  logic tdo, tdo_en;
  logic [NIN-1:0]  pin_in   = 3'b101;
  logic [NOUT-1:0] core_out = 2'b10, core_oe = 2'b11;
  logic [NOUT-1:0] pin_out, pin_oe;
  int checks = 0, errors = 0;

  tap_ctrl #(.NIN(NIN), .NOUT(NOUT)) dut (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .gts(gts), .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
    .pin_out(pin_out), .pin_oe(pin_oe));

  always #2.5 tck = ~tck;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [BLEN-1:0] mkcap(input logic [NIN-1:0] i,
      input logic [NOUT-1:0] o, input logic [NOUT-1:0] e);
    logic [BLEN-1:0] v;
    v = '0;
    v[NIN-1:0] = i;
    for (int j = 0; j < NOUT; j++) begin
      v[NIN+2*j] = o[j];
      v[NIN+2*j+1] = e[j];
    end
    return v;
  endfunction

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic scan(input bit is_ir, input int n, input logic [15:0] din,
      output logic [15:0] dout, input bit hold_chk, input bit edge_chk);
    logic [NOUT-1:0] po, pe;
    po = pin_out; pe = pin_oe;
    dout = '0;
    step(1, 0);
    if (is_ir) step(1, 0);
    step(0, 0);
    step(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      chk("R9 tdo_en in shift", {31'd0, tdo_en}, 32'd1);
      if (hold_chk) begin
        chk("R6 pin_out stable while shifting", {30'd0, pin_out}, {30'd0, po});
        chk("R6 pin_oe stable while shifting", {30'd0, pin_oe}, {30'd0, pe});
      end
      if (edge_chk && i == 0) begin
        logic t;
        t = tdo;
        tms = 1'b0; tdi = din[0];
        @(posedge tck); #1;
        chk("R9 tdo holds past rising edge", {31'd0, tdo}, {31'd0, t});
        @(negedge tck); #1;
      end else begin
        step(i == n-1, din[i]);
      end
    end
    chk("R9 tdo_en off after shift", {31'd0, tdo_en}, 32'd0);
    step(1, 0);
    if (hold_chk) chk("R6 pins unchanged in Update-DR", {28'd0, pin_oe, pin_out}, {28'd0, pe, po});
    step(0, 0);
  endtask

  logic [15:0] r;

  initial begin
    #12 por_n = 1'b1;
    @(negedge tck); #1;
    chk("R1 tdo_en after reset", {31'd0, tdo_en}, 32'd0);
    chk("R1 R10 pin_out follows core", {30'd0, pin_out}, {30'd0, core_out});
    chk("R1 R10 pin_oe follows core", {30'd0, pin_oe}, {30'd0, core_oe});
    step(0, 0);

    scan(1, 3, 16'h7, r, 0, 0);
    chk("R3 IR capture pattern", {29'd0, r[2:0]}, 32'h5);
    scan(0, 8, 16'hCA, r, 0, 1);
    chk("R4 bypass one-bit delay", {24'd0, r[7:0]}, {24'd0, 8'h94});

    gts = 1'b1; #1;
    chk("R8 float under bypass", {30'd0, pin_oe}, 32'd0);
    gts = 1'b0; #1;
    chk("R10 enables back to core", {30'd0, pin_oe}, {30'd0, core_oe});

    scan(1, 3, 16'h1, r, 0, 0);
    scan(0, BLEN, 16'h4B, r, 0, 0);
    chk("R5 sample capture order", {25'd0, r[6:0]}, {25'd0, mkcap(pin_in, core_out, core_oe)});
    chk("R10 preload leaves pins on core", {28'd0, pin_oe, pin_out}, {28'd0, core_oe, core_out});

    scan(1, 3, 16'h0, r, 0, 0);
    chk("R7 extest drives preloaded data", {30'd0, pin_out}, 32'h1);
    chk("R7 extest drives preloaded enables", {30'd0, pin_oe}, 32'h2);
    gts = 1'b1; #1;
    chk("R8 float ignored under extest", {30'd0, pin_oe}, 32'h2);

    scan(0, BLEN, 16'h38, r, 1, 0);
    chk("R5 extest capture of driven pins", {25'd0, r[6:0]}, {25'd0, mkcap(pin_in, 2'b01, 2'b10)});
    chk("R6 R7 pins after update", {28'd0, pin_oe, pin_out}, {28'd0, 2'b01, 2'b11});

    step(1, 0); step(0, 0); step(0, 0);
    for (int k = 0; k < 5; k++) step(1, 0);
    chk("R2 reset path restores core data", {30'd0, pin_out}, {30'd0, core_out});
    chk("R2 R8 float active again after reset", {30'd0, pin_oe}, 32'd0);
    chk("R2 tdo_en off in reset", {31'd0, tdo_en}, 32'd0);
    gts = 1'b0;
    step(0, 0);
    chk("R10 core enables after reset", {30'd0, pin_oe}, {30'd0, core_oe});

    scan(1, 3, 16'h2, r, 0, 0);
    scan(0, 4, 16'hB, r, 0, 0);
    chk("R3 unused code acts as bypass", {28'd0, r[3:0]}, 32'h6);
    chk("R3 unused code keeps core pins", {28'd0, pin_oe, pin_out}, {28'd0, core_oe, core_out});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule